// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts the next fetch address for the front end of a pipelined processor. It is a direct-mapped table. Each slot holds a valid bit, an address tag, the branch target last seen and a two-bit direction state. Every cycle the fetch stage presents its program counter. The table answers in the same cycle with a hit flag, a taken prediction and the address to fetch next. Program counters are word addresses, so the sequential successor of a PC is PC plus one.

When a branch resolves in execute, the update port reports the branch PC, its real direction, its real target and whether the earlier prediction was right. A matching slot has its direction state advanced and its target refreshed. Otherwise the slot selected by the index is overwritten with the new branch. The block does not flush the pipeline itself. One cycle after a wrongly predicted branch is reported, it raises a redirect with the correct restart address, and the surrounding pipeline acts on that.

On a miss, the fetch unit may supply the target it decoded from the instruction. A static rule then predicts taken only for a backward branch.

Top module: `branch_history_predictor`

## Requirements
- R1: While reset is asserted, and after it is released, every slot is invalid, so every lookup misses until an update writes a slot.
- R2: On a miss with `lk_tgt_valid` low, `lk_taken` is 0 and `lk_next_pc` is `lk_pc`+1.
- R3: On a miss with `lk_tgt_valid` high, `lk_taken` is 1 and `lk_next_pc` is `lk_tgt` when `lk_tgt` is below `lk_pc` (unsigned compare). Otherwise `lk_taken` is 0 and `lk_next_pc` is `lk_pc`+1.
- R4: On a hit, the slot's state predicts taken when its bit 0 is 1 (states 2'b11 and 2'b01), and `lk_next_pc` is then the stored target. States 2'b10 and 2'b00 predict not taken, and `lk_next_pc` is then `lk_pc`+1.
- R5: An update that misses allocates the slot with state 2'b11 if the branch was taken and 2'b00 if it was not. The reported target is stored.
- R6: An update that hits moves the state as follows. On taken: 11 stays 11, 01 goes to 11, 00 goes to 10, 10 goes to 11. On not taken: 11 goes to 01, 01 goes to 00, 10 goes to 00, 00 stays 00. The target is refreshed.
- R7: The slot index is PC bits [IDX_W-1:0] and the tag is the remaining upper bits. An update whose tag differs from the stored one replaces that slot, so the old branch then misses.
- R8: A lookup and an update in the same cycle to the same slot: the lookup returns the state from before the update.
- R9: One cycle after an update with `up_pred_ok` low, `redirect_valid` is 1 and `redirect_pc` is `up_target` if taken, else `up_pc`+1. After any other cycle `redirect_valid` is 0.
- R10: When `up_valid` is low, the other update inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC for lookup |
| lk_tgt_valid | input | 1 | Fetch unit decoded a branch target for `lk_pc` |
| lk_tgt | input | PC_W | Decoded target used by the static rule on a miss |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_taken | output | 1 | Predicted taken |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Real direction |
| up_target | input | PC_W | Real target |
| up_pred_ok | input | 1 | Earlier prediction was correct |
| redirect_valid | output | 1 | Mispredict: restart fetch |
| redirect_pc | output | PC_W | Correct restart address |

## Verification
The bench walks one slot through all four states, so that a swapped encoding shows up. If the states 01 and 10 were mixed up, the second not-taken outcome would flip the prediction one step early. The bench issues a lookup in the same cycle as the update to that slot, so a write-through path would return the new state. It also sends two PCs that share an index but carry different tags; a design that compared too few tag bits would report a false hit after the eviction. The static rule is tested on both sides of the PC, and the compare must be unsigned. Update inputs that wiggle while `up_valid` is low must leave the table unchanged and must not raise a redirect.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef logic [1:0] bht_ctr_t;

  localparam bht_ctr_t CTR_T_HI = 2'b11;
  localparam bht_ctr_t CTR_T_LO = 2'b01;
  localparam bht_ctr_t CTR_N_HI = 2'b10;
  localparam bht_ctr_t CTR_N_LO = 2'b00;

  // Direction state step on a resolved outcome.
  function automatic bht_ctr_t ctr_step(input bht_ctr_t cur, input logic taken);
    bht_ctr_t nxt;
    unique case (cur)
      CTR_T_HI: nxt = taken ? CTR_T_HI : CTR_T_LO;
      CTR_T_LO: nxt = taken ? CTR_T_HI : CTR_N_LO;
      CTR_N_HI: nxt = taken ? CTR_T_HI : CTR_N_LO;
      default:  nxt = taken ? CTR_N_HI : CTR_N_LO;
    endcase
    return nxt;
  endfunction

  function automatic bht_ctr_t ctr_alloc(input logic taken);
    return taken ? CTR_T_HI : CTR_N_LO;
  endfunction
endpackage

// File: rtl/bht_rst_sync.sv
module bht_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bht_table.sv
module bht_table
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output bht_ctr_t         rd_ctr,
  output logic [PC_W-1:0]  rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_taken,
  input  logic [PC_W-1:0]  wr_target
);
  logic             valid_q  [ENTRIES];
  logic [TAG_W-1:0] tag_q    [ENTRIES];
  bht_ctr_t         ctr_q    [ENTRIES];
  logic [PC_W-1:0]  target_q [ENTRIES];

  logic     wr_hit;
  bht_ctr_t wr_ctr_d;

  always_comb begin
    wr_hit   = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    wr_ctr_d = wr_hit ? ctr_step(ctr_q[wr_idx], wr_taken) : ctr_alloc(wr_taken);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q[g] <= 1'b0;
      else if (slot_we) valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[g]    <= wr_tag;
        ctr_q[g]    <= wr_ctr_d;
        target_q[g] <= wr_target;
      end
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_ctr    = ctr_q[rd_idx];
  assign rd_target = target_q[rd_idx];

  // R5: a written slot is valid afterwards
  a_r5_slot_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  // R6: the upper state bit always records the last outcome
  a_r6_msb_tracks_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctr_q[$past(wr_idx)][1] == $past(wr_taken));

  // R7: the slot takes the tag of the last writer
  a_r7_tag_replaced: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tag_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/bht_lookup_sel.sv
module bht_lookup_sel
  import bht_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  localparam int TAG_W = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pc,
  input  logic             tgt_valid,
  input  logic [PC_W-1:0]  tgt,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  bht_ctr_t         slot_ctr,
  input  logic [PC_W-1:0]  slot_target,
  output logic             hit,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);
  logic [PC_W-1:0] seq_pc;
  logic            static_taken;

  always_comb begin
    seq_pc       = pc + PC_W'(1);
    hit          = slot_valid && (slot_tag == pc[PC_W-1:IDX_W]);
    static_taken = tgt_valid && (tgt < pc);
    if (hit) begin
      taken   = slot_ctr[0];
      next_pc = slot_ctr[0] ? slot_target : seq_pc;
    end else begin
      taken   = static_taken;
      next_pc = static_taken ? tgt : seq_pc;
    end
  end

  // R4: a hit in a not-taken state falls through
  a_r4_hit_nt_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !slot_ctr[0]) |-> (!taken && next_pc == pc + PC_W'(1)));

  // R3: a forward decoded target never predicts taken on a miss
  a_r3_forward_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && tgt_valid && tgt >= pc) |-> !taken);
endmodule

// File: rtl/branch_history_predictor.sv
module branch_history_predictor
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  input  logic            lk_tgt_valid,
  input  logic [PC_W-1:0] lk_tgt,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic [PC_W-1:0] up_target,
  input  logic            up_pred_ok,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic             rst_n_s;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  bht_ctr_t         rd_ctr;
  logic [PC_W-1:0]  rd_target;

  bht_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  bht_table #(.PC_W(PC_W), .ENTRIES(ENTRIES)) i_table (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_idx   (lk_pc[IDX_W-1:0]),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_ctr   (rd_ctr),
    .rd_target(rd_target),
    .wr_en    (up_valid),
    .wr_idx   (up_pc[IDX_W-1:0]),
    .wr_tag   (up_pc[PC_W-1:IDX_W]),
    .wr_taken (up_taken),
    .wr_target(up_target)
  );

  bht_lookup_sel #(.PC_W(PC_W), .IDX_W(IDX_W)) i_sel (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .pc         (lk_pc),
    .tgt_valid  (lk_tgt_valid),
    .tgt        (lk_tgt),
    .slot_valid (rd_valid),
    .slot_tag   (rd_tag),
    .slot_ctr   (rd_ctr),
    .slot_target(rd_target),
    .hit        (lk_hit),
    .taken      (lk_taken),
    .next_pc    (lk_next_pc)
  );

  // Redirect: next-state and register processes
  logic            redir_d;
  logic [PC_W-1:0] redir_pc_d;
  logic            redir_pc_en;

  always_comb begin
    redir_d     = up_valid && !up_pred_ok;
    redir_pc_en = redir_d;
    redir_pc_d  = up_taken ? up_target : (up_pc + PC_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) redirect_valid <= 1'b0;
    else          redirect_valid <= redir_d;
  end

  always_ff @(posedge clk) begin
    if (redir_pc_en) redirect_pc <= redir_pc_d;
  end

  // R9: a reported mispredict raises redirect next cycle with the right address
  a_r9_redirect_on_mispredict: assert property (@(posedge clk) disable iff (!rst_n_s)
    (up_valid && !up_pred_ok) |=>
      (redirect_valid && redirect_pc == ($past(up_taken) ? $past(up_target) : $past(up_pc) + PC_W'(1))));

  // R9: no redirect without a reported mispredict
  a_r9_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(up_valid && !up_pred_ok) |=> !redirect_valid);

  // R2: miss without decoded target falls through
  a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!lk_hit && !lk_tgt_valid) |-> (!lk_taken && lk_next_pc == lk_pc + PC_W'(1)));
endmodule

// File: tb/test_branch_history_predictor.sv
`timescale 1ns/1ps
module test_branch_history_predictor;
  localparam int PC_W = 32;
  localparam int ENT  = 64;
  localparam int IW   = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [PC_W-1:0] lk_pc, lk_tgt, lk_next_pc, up_pc, up_target, redirect_pc;
  logic lk_tgt_valid, lk_hit, lk_taken, up_valid, up_taken, up_pred_ok, redirect_valid;

  always #2 clk = ~clk;

  branch_history_predictor #(.PC_W(PC_W), .ENTRIES(ENT)) i_branch_history_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_tgt_valid(lk_tgt_valid), .lk_tgt(lk_tgt),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
    .up_pred_ok(up_pred_ok), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc));

  // behavioural reference state
  bit              mv   [ENT];
  logic [PC_W-1:0] mpc  [ENT];
  int              mst  [ENT];
  logic [PC_W-1:0] mtg  [ENT];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input string what, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int step_st(input int s, input bit t);
    case (s)
      3: return t ? 3 : 1;
      1: return t ? 3 : 0;
      2: return t ? 3 : 0;
      default: return t ? 2 : 0;
    endcase
  endfunction

  task automatic step(input string req,
                      input logic [PC_W-1:0] pc, input bit tv, input logic [PC_W-1:0] tg,
                      input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                      input logic [PC_W-1:0] utg, input bit uok);
    int i, j;
    bit eh, et;
    logic [PC_W-1:0] en;
    lk_pc = pc; lk_tgt_valid = tv; lk_tgt = tg;
    up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg; up_pred_ok = uok;
    #1;
    i  = int'(pc % ENT);
    eh = mv[i] && (mpc[i] / ENT == pc / ENT);
    if (eh) et = (mst[i] % 2) == 1;
    else    et = tv && (tg < pc);
    en = et ? (eh ? mtg[i] : tg) : pc + 1;
    chk(req, "lk_hit", {31'd0, lk_hit}, {31'd0, eh});
    chk(req, "lk_taken", {31'd0, lk_taken}, {31'd0, et});
    chk(req, "lk_next_pc", lk_next_pc, en);
    @(posedge clk);
    if (uv) begin
      j = int'(upc % ENT);
      if (mv[j] && (mpc[j] / ENT == upc / ENT)) mst[j] = step_st(mst[j], ut);
      else mst[j] = ut ? 3 : 0;
      mv[j] = 1; mpc[j] = upc; mtg[j] = utg;
    end
    @(negedge clk);
    chk(req, "redirect_valid", {31'd0, redirect_valid}, {31'd0, uv && !uok});
    if (uv && !uok) chk(req, "redirect_pc", redirect_pc, ut ? utg : upc + 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int k = 0; k < ENT; k++) begin mv[k] = 0; mst[k] = 0; end
    rst_n = 0; lk_pc = 0; lk_tgt_valid = 0; lk_tgt = 0;
    up_valid = 0; up_pc = 0; up_taken = 0; up_target = 0; up_pred_ok = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 / R2: empty table after reset
    step("R1", 32'h40, 0, 0, 0, 0, 0, 0, 1);
    step("R2", 32'hFFFF_FFC5, 0, 0, 0, 0, 0, 0, 1);
    // R3: static rule both directions, unsigned
    step("R3", 32'd100, 1, 32'd80, 0, 0, 0, 0, 1);
    step("R3", 32'd100, 1, 32'd120, 0, 0, 0, 0, 1);
    step("R3", 32'h10, 1, 32'hFFFF_0000, 0, 0, 0, 0, 1);
    // R5 / R9: allocate taken with mispredict
    step("R5", 32'h0, 0, 0, 1, 32'h40, 1, 32'h10, 0);
    step("R4", 32'h40, 0, 0, 0, 0, 0, 0, 1);
    // R6 / R8: walk states, lookup in same cycle sees pre-update value
    step("R8", 32'h40, 0, 0, 1, 32'h40, 0, 32'h10, 0);   // 11 -> 01
    step("R6", 32'h40, 0, 0, 1, 32'h40, 0, 32'h10, 1);   // 01 -> 00
    step("R6", 32'h40, 0, 0, 1, 32'h40, 1, 32'h14, 0);   // 00 -> 10
    step("R6", 32'h40, 0, 0, 1, 32'h40, 1, 32'h14, 0);   // 10 -> 11
    step("R6", 32'h40, 0, 0, 1, 32'h40, 0, 32'h14, 0);   // 11 -> 01
    step("R6", 32'h40, 0, 0, 1, 32'h40, 1, 32'h18, 1);   // 01 -> 11
    step("R6", 32'h40, 0, 0, 1, 32'h40, 1, 32'h18, 1);   // 11 stays
    step("R4", 32'h40, 0, 0, 0, 0, 0, 0, 1);
    // R5: allocate not taken
    step("R5", 32'h0, 0, 0, 1, 32'h105, 0, 32'h3, 1);
    step("R4", 32'h105, 1, 32'h3, 0, 0, 0, 0, 1);
    // R7: alias evicts
    step("R7", 32'h0, 0, 0, 1, 32'h80, 0, 32'h99, 1);
    step("R7", 32'h40, 1, 32'h20, 0, 0, 0, 0, 1);
    step("R7", 32'h80, 0, 0, 0, 0, 0, 0, 1);
    // R10: update inputs toggle with valid low
    step("R10", 32'h80, 0, 0, 0, 32'h80, 1, 32'h7, 0);
    step("R10", 32'h80, 0, 0, 0, 32'hC0, 1, 32'h7, 0);
    step("R10", 32'hC0, 0, 0, 0, 0, 0, 0, 1);
    // mixed traffic against the model
    r = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      r = r * 32'd1664525 + 32'd1013904223;
      a = 32'h1000 + (r[23:8] % 160);
      b = 32'h1000 + (r[31:16] % 160);
      step("R6", a, r[3], 32'h1000 + r[15:8], r[0] | r[1], b, r[2], 32'h800 + r[11:4], r[5]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule